// File: doc/BRIEF.md
# Collision-Vector Pipeline Initiation Scheduler

This block decides, one clock at a time, whether a new task may enter a non-linear pipeline whose stage usage pattern is fixed. It holds a collision state register. Each bit of that register marks a future cycle in which a fresh initiation would share a stage with a task that is already in flight. The forbidden-latency pattern is a parameter of the block. A requester pulses a start request. The block answers with a grant in the first cycle that is free of collisions, and reports how many cycles have passed since the previous grant.

Requests are served greedily. A request on a free cycle is granted in that same cycle. A request on a blocked cycle is held and granted on the first free cycle after it. When the request line is held high, the grant times follow the shortest latencies that the state permits at each step, so the block settles into the greedy latency cycle of the pattern. The pipeline datapath and the derivation of the pattern from a reservation table are outside this block.

Top module: `pipe_init_sched`

## Requirements
- R1: After reset is released, `gnt_o` stays low while no request is made. The first request after reset is granted in the cycle it appears, with `lat_o` = 0.
- R2: Parameter bit `COLL_VEC[k]` set to 1 means latency k+1 is forbidden (bit 0 is latency 1). A grant is never issued at a forbidden latency from any earlier grant that is still within `EVAL_T`-1 cycles.
- R3: When a request appears on a free cycle, `gnt_o` rises combinationally in that same cycle.
- R4: A request made on a blocked cycle is held. It is granted on the first free cycle that follows, without the request being repeated.
- R5: Further requests that arrive while one is already held merge into it and produce no extra grant.
- R6: A latency of `EVAL_T` cycles or more after the last grant is always free.
- R7: With each grant, `lat_o` gives the number of cycles since the previous grant, saturating at 2^`LAT_W`-1.
- R8: With `COLL_VEC` = 1011010, a request held high from the first grant gives latencies 1,8,1,8,... A request at cycle 0, then none until cycle 3, then held high, gives latencies 3,3,3,...
- R9: Without a grant, the state moves one latency step per cycle. A grant adds the full pattern to the state. With `COLL_VEC` = 1010 and a request held high, this gives latencies 1,5,1,5,...

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 1 | Start request, one pulse per task |
| gnt_o | output | 1 | Initiation granted in this cycle |
| lat_o | output | LAT_W | Cycles since the previous grant, valid with `gnt_o` |

## Verification
A wrong state bit shows at the ports as a grant that comes one or more cycles too early or too late. The error appears at the first request after the bit goes wrong, and never later than `EVAL_T`-1 cycles after the faulty grant. A merged or lost pending request shows as an extra or missing grant once the blocked window ends. A broken latency counter shows in `lat_o` on the very next grant. The bench runs a model of the past grants in parallel and compares every cycle of both pattern instances against it. This exposes a timing error in the cycle where it occurs.

// File: rtl/pis_pkg.sv
package pis_pkg;

  typedef enum logic {
    PEND_CLEAR = 1'b0,
    PEND_HELD  = 1'b1
  } pend_e;

  function automatic int sat_top(input int width);
    return (1 << width) - 1;
  endfunction

endpackage

// File: rtl/pis_rst_sync.sv
module pis_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;

endmodule

// File: rtl/pis_coll_state.sv
module pis_coll_state #(
  parameter int              W  = 7,
  parameter logic [W-1:0]    CV = 7'b1011010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  output logic free_o
);

  logic [W-1:0] st_q;
  logic [W-1:0] st_d;

  // bit k of the state: an initiation k cycles from now would collide
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == W - 1) begin : g_top
        assign st_d[i] = take_i & CV[i];
      end else begin : g_mid
        assign st_d[i] = st_q[i+1] | (take_i & CV[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign free_o = ~st_q[0];

  // R9
  cv_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> ((st_q & CV) == CV));

  // R9
  top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> (st_q[W-1] == 1'b0));

endmodule

// File: rtl/pis_lat_cnt.sv
module pis_lat_cnt #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  output logic [LAT_W-1:0] lat_o
);

  localparam logic [LAT_W-1:0] LAT_MAX = LAT_W'(pis_pkg::sat_top(LAT_W));

  logic             first_q;
  logic             first_d;
  logic [LAT_W-1:0] cnt_q;
  logic [LAT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en  = take_i | (cnt_q != LAT_MAX);
    cnt_d   = take_i ? LAT_W'(1) : cnt_q + LAT_W'(1);
    first_d = first_q & ~take_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      first_q <= first_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign lat_o = first_q ? '0 : cnt_q;

  // R7
  lat_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !first_q) |-> (lat_o != '0));

  // R7
  lat_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (cnt_q == LAT_W'(1)));

endmodule

// File: rtl/pis_req_hold.sv
module pis_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic live_i,
  input  logic req_i,
  input  logic free_i,
  output logic take_o
);

  import pis_pkg::*;

  pend_e pend_q;
  pend_e pend_d;
  logic  want;

  always_comb begin
    want   = req_i | (pend_q == PEND_HELD);
    take_o = live_i & want & free_i;
    pend_d = (want && !take_o) ? PEND_HELD : PEND_CLEAR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PEND_CLEAR;
    end else if (live_i) begin
      pend_q <= pend_d;
    end
  end

  // R4
  pend_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && pend_q == PEND_HELD && free_i) |-> take_o);

  // R5
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && take_o && !req_i) |=> (pend_q == PEND_CLEAR));

endmodule

// File: rtl/pipe_init_sched.sv
module pipe_init_sched #(
  parameter int                  EVAL_T   = 8,
  parameter logic [EVAL_T-2:0]   COLL_VEC = 7'b1011010,
  parameter int                  LAT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  output logic             gnt_o,
  output logic [LAT_W-1:0] lat_o
);

  localparam int CV_W = EVAL_T - 1;

  logic live;
  logic free;
  logic take;

  pis_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (live)
  );

  pis_req_hold u_req_hold (
    .clk    (clk),
    .rst_n  (live),
    .live_i (live),
    .req_i  (req_i),
    .free_i (free),
    .take_o (take)
  );

  pis_coll_state #(
    .W  (CV_W),
    .CV (COLL_VEC)
  ) u_coll_state (
    .clk    (clk),
    .rst_n  (live),
    .take_i (take),
    .free_o (free)
  );

  pis_lat_cnt #(
    .LAT_W (LAT_W)
  ) u_lat_cnt (
    .clk    (clk),
    .rst_n  (live),
    .take_i (take),
    .lat_o  (lat_o)
  );

  assign gnt_o = take;

  logic forbid_hit;
  always_comb begin
    forbid_hit = 1'b0;
    for (int k = 0; k < CV_W; k++) begin
      if (COLL_VEC[k] && (lat_o == LAT_W'(k + 1))) begin
        forbid_hit = 1'b1;
      end
    end
  end

  // R2
  no_collision_chk: assert property (@(posedge clk) disable iff (!live)
    gnt_o |-> !forbid_hit);

  // R1
  quiet_reset_chk: assert property (@(posedge clk)
    !live |-> !gnt_o);

endmodule

// File: tb/pipe_init_sched_bench.sv
module pipe_init_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LW   = 4;
  localparam int WA   = 7;
  localparam int WB   = 4;
  localparam int LMAX = (1 << LW) - 1;
  localparam logic [6:0] CVA = 7'b1011010;
  localparam logic [3:0] CVB = 4'b1010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_a = 1'b0;
  logic req_b = 1'b0;
  logic gnt_a, gnt_b;
  logic [LW-1:0] lat_a, lat_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_init_sched #(.EVAL_T(8), .COLL_VEC(CVA), .LAT_W(LW)) u_pipe_init_sched (
    .clk(clk), .rst_n(rst_n), .req_i(req_a), .gnt_o(gnt_a), .lat_o(lat_a));

  pipe_init_sched #(.EVAL_T(5), .COLL_VEC(CVB), .LAT_W(LW)) u_pipe_init_sched_v4 (
    .clk(clk), .rst_n(rst_n), .req_i(req_b), .gnt_o(gnt_b), .lat_o(lat_b));

  int n_cmp = 0;
  int n_bad = 0;

  // model: past grant history, bit d-1 = a grant d cycles ago
  bit [15:0] hist_a, hist_b;
  bit pend_a, pend_b, first_a, first_b;
  int since_a, since_b;
  int log_a[$];
  int log_b[$];

  function automatic bit is_free(bit [15:0] hist, bit [15:0] cv, int w);
    for (int d = 1; d <= w; d++) begin
      if (hist[d-1] && cv[d-1]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit ra, bit rb, string tag);
    bit ea, eb;
    req_a = ra;
    req_b = rb;
    #1;
    ea = (ra || pend_a) && is_free(16'(hist_a), 16'(CVA), WA);
    eb = (rb || pend_b) && is_free(16'(hist_b), 16'(CVB), WB);
    chk({tag, " gnt A"}, int'(gnt_a), int'(ea));
    chk({tag, " gnt B"}, int'(gnt_b), int'(eb));
    if (ea && gnt_a) chk({tag, " R7 lat A"}, int'(lat_a), first_a ? 0 : since_a);
    if (eb && gnt_b) chk({tag, " R7 lat B"}, int'(lat_b), first_b ? 0 : since_b);
    if (gnt_a) log_a.push_back(int'(lat_a));
    if (gnt_b) log_b.push_back(int'(lat_b));
    @(posedge clk);
    pend_a = (ra || pend_a) && !ea;
    pend_b = (rb || pend_b) && !eb;
    hist_a = {hist_a[14:0], ea};
    hist_b = {hist_b[14:0], eb};
    since_a = ea ? 1 : (since_a < LMAX ? since_a + 1 : LMAX);
    since_b = eb ? 1 : (since_b < LMAX ? since_b + 1 : LMAX);
    if (ea) first_a = 1'b0;
    if (eb) first_b = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    req_a = 1'b0;
    req_b = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset gnt A", int'(gnt_a), 0);
    chk("R1 reset gnt B", int'(gnt_b), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    hist_a = '0; hist_b = '0;
    pend_a = 1'b0; pend_b = 1'b0;
    first_a = 1'b1; first_b = 1'b1;
    since_a = 0; since_b = 0;
    log_a.delete();
    log_b.delete();
  endtask

  task automatic t_first();
    do_reset();
    step(1'b0, 1'b0, "R1 idle");
    step(1'b1, 1'b1, "R1 R3 first");
    chk("R1 first lat A", log_a.size() > 0 ? log_a[0] : -1, 0);
    chk("R1 first lat B", log_b.size() > 0 ? log_b[0] : -1, 0);
  endtask

  task automatic t_greedy_held();
    int ea[5] = '{0, 1, 8, 1, 8};
    int eb[5] = '{0, 1, 5, 1, 5};
    do_reset();
    for (int i = 0; i < 24; i++) step(1'b1, 1'b1, "R2 R3 held");
    for (int i = 0; i < 5; i++) begin
      chk("R8 cycle 1,8", log_a.size() > i ? log_a[i] : -1, ea[i]);
      chk("R9 cycle 1,5", log_b.size() > i ? log_b[i] : -1, eb[i]);
    end
  endtask

  task automatic t_greedy_three();
    do_reset();
    step(1'b1, 1'b1, "R8 start");
    step(1'b0, 1'b0, "R8 gap");
    step(1'b0, 1'b0, "R8 gap");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "R8 held");
    for (int i = 1; i < 5; i++)
      chk("R8 cycle 3", log_a.size() > i ? log_a[i] : -1, 3);
  endtask

  task automatic t_pending();
    do_reset();
    step(1'b1, 1'b1, "R4 t0");
    step(1'b1, 1'b1, "R4 t1");
    step(1'b0, 1'b0, "R4 t2");
    step(1'b1, 1'b0, "R4 blocked req");
    step(1'b0, 1'b0, "R4 wait");
    step(1'b1, 1'b0, "R5 merge req");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, "R4 R5 drain");
    chk("R5 grant count A", log_a.size(), 3);
    chk("R4 held lat A", log_a.size() > 2 ? log_a[2] : -1, 8);
  endtask

  task automatic t_idle_sat();
    do_reset();
    step(1'b1, 1'b1, "R6 t0");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, "R6 idle");
    step(1'b1, 1'b1, "R6 R7 late");
    chk("R7 saturated lat A", log_a.size() > 1 ? log_a[1] : -1, LMAX);
    do_reset();
    step(1'b1, 1'b1, "R6 t0");
    for (int i = 0; i < 7; i++) step(1'b0, 1'b0, "R6 idle");
    step(1'b1, 1'b1, "R6 at n");
    chk("R6 lat n A", log_a.size() > 1 ? log_a[1] : -1, 8);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_first();
    t_greedy_held();
    t_greedy_three();
    t_pending();
    t_idle_sat();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule